// File: doc/BRIEF.md
# UART Receive Character Buffer

This block is the receive-side store of a serial port. Characters arrive one per cycle from a deserializer as a data byte with error bits above it, and a register-read port removes them in arrival order. The block keeps the empty and full indications, a receive interrupt request, a small status register that holds the error bits of the most recently read character, and a one-cycle overrun pulse for the interrupt logic.

A mode input selects between a buffered mode, where the usable depth is the power-of-two parameter `DEPTH`, and a holding mode, where exactly one character can be held. Flipping the mode input in either direction discards everything stored. A separate input pushes a line-break marker, which is stored as an ordinary entry whose only set bit is the break bit.

Top module: `uart_rx_fifo`

## Requirements
- R1: After reset the buffer is empty: `rxEmpty` is 1, `rxFull` is 0, `rxIrq` is 0, `overrunPulse` is 0 and `rxStatus` is 0.
- R2: In buffered mode (`fifoEn` = 1) up to `DEPTH` entries are accepted, and `popEntry` presents them in arrival order, including across pointer wrap-around.
- R3: In holding mode (`fifoEn` = 0) one entry makes `rxFull` 1; a further push is not stored.
- R4: A change of `fifoEn` in either direction discards all stored entries: from the next cycle `rxEmpty` is 1, `rxFull` is 0 and `rxIrq` is 0.
- R5: An entry is `ERR_W` error bits above a `DATA_W`-bit byte; bit `DATA_W+2` (bit 10 by default) is the break bit. A `pushBreak` stores an entry with only that bit set (0x400 by default).
- R6: `rxEmpty` is 1 exactly when no entry is stored and `rxFull` is 1 exactly when the stored count equals the effective depth; `rxFlags` carries `rxEmpty` at bit 4 and `rxFull` at bit 6, with all other bits 0.
- R7: `rxIrq` is 1 whenever at least one entry is stored (trigger level one) and 0 otherwise.
- R8: A pop copies the head entry's bits above the byte into `rxStatus` on the next cycle; `statusClr` without a pop clears `rxStatus` to 0.
- R9: A pop of an empty buffer presents the head slot on `popEntry` and changes neither the contents nor the flags.
- R10: A push (data or break) while `rxFull` is 1 is dropped and `overrunPulse` is 1 for exactly the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| fifoEn | input | 1 | 1 selects buffered mode, 0 selects one-entry holding mode |
| pushValid | input | 1 | Store `pushEntry` this cycle |
| pushEntry | input | DATA_W+ERR_W | Character with error bits from the deserializer |
| pushBreak | input | 1 | Store a break-marker entry this cycle (has priority over `pushValid`) |
| popReq | input | 1 | Data read: remove the head entry |
| popEntry | output | DATA_W+ERR_W | Current head slot |
| statusClr | input | 1 | Write strobe to the status register; clears it |
| rxStatus | output | ERR_W | Error bits of the last read entry |
| rxEmpty | output | 1 | No entry stored |
| rxFull | output | 1 | Stored count equals effective depth |
| rxFlags | output | 8 | Flag byte: bit 4 empty, bit 6 full |
| rxIrq | output | 1 | Receive interrupt request |
| overrunPulse | output | 1 | One-cycle pulse after a dropped push |

## Verification
The bench builds the block with `DEPTH` = 4 and the default 8-bit byte with four error bits. The small depth lets the bench fill the buffer, overrun it and wrap both pointers within a few dozen cycles, while the one-entry holding mode is reached by flipping the mode input, which also exercises the flush on both edges of that input.

// File: rtl/uart_rx_fifo_pkg.sv
package uart_rx_fifo_pkg;
  // Strobes from control to datapath, one set per cycle
  typedef struct packed {
    logic flush;     // discard everything
    logic push;      // write one entry at the tail
    logic pop;       // advance the head
    logic useBreak;  // the written entry is the break marker
    logic wide;      // buffered mode in effect
  } rxqStrobe_t;
endpackage

// File: rtl/uart_rx_fifo_dp.sv
module uart_rx_fifo_dp
  import uart_rx_fifo_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int ENT_W = 12,
  parameter int BRK_BIT = 10,
  parameter int PTR_W = $clog2(DEPTH),
  parameter int CNT_W = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  rxqStrobe_t       str,
  input  logic [ENT_W-1:0] pushEntry,
  output logic [ENT_W-1:0] headEntry,
  output logic [CNT_W-1:0] count
);
  localparam logic [ENT_W-1:0] BRK_WORD = ENT_W'(1) << BRK_BIT;

  logic [ENT_W-1:0] store [DEPTH];
  logic [PTR_W-1:0] rdPtr;
  logic [PTR_W-1:0] wrPtr;
  logic [PTR_W-1:0] ptrMask;
  logic [ENT_W-1:0] wrData;

  // Holding mode folds every slot index onto slot zero
  assign ptrMask = str.wide ? {PTR_W{1'b1}} : {PTR_W{1'b0}};
  assign wrPtr = (rdPtr + count[PTR_W-1:0]) & ptrMask;
  assign wrData = str.useBreak ? BRK_WORD : pushEntry;
  assign headEntry = store[rdPtr];

  always_ff @(posedge clk) begin
    if (str.push) store[wrPtr] <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdPtr <= '0;
      count <= '0;
    end else if (str.flush) begin
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (str.pop) rdPtr <= (rdPtr + 1'b1) & ptrMask;
      case ({str.push, str.pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/uart_rx_fifo_ctl.sv
module uart_rx_fifo_ctl
  import uart_rx_fifo_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DATA_W = 8,
  parameter int ERR_W = 4,
  parameter int CNT_W = $clog2(DEPTH) + 1
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    fifoEn,
  input  logic                    pushValid,
  input  logic                    pushBreak,
  input  logic                    popReq,
  input  logic                    statusClr,
  input  logic [CNT_W-1:0]        count,
  input  logic [DATA_W+ERR_W-1:0] headEntry,
  output rxqStrobe_t              str,
  output logic                    rxEmpty,
  output logic                    rxFull,
  output logic                    rxIrq,
  output logic                    overrunPulse,
  output logic [ERR_W-1:0]        rxStatus
);
  logic             fifoEnQ;
  logic             modeFlip;
  logic             pushAny;
  logic [CNT_W-1:0] effDepth;

  assign modeFlip = fifoEnQ != fifoEn;
  assign pushAny  = pushValid | pushBreak;
  // Depth follows the mode the stored count was built under
  assign effDepth = fifoEnQ ? CNT_W'(DEPTH) : CNT_W'(1);
  assign rxEmpty  = count == '0;
  assign rxFull   = count == effDepth;

  always_comb begin
    str.flush    = modeFlip;
    str.push     = !modeFlip && pushAny && !rxFull;
    str.pop      = !modeFlip && popReq && !rxEmpty;
    str.useBreak = pushBreak;
    str.wide     = fifoEnQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fifoEnQ      <= 1'b0;
      overrunPulse <= 1'b0;
      rxIrq        <= 1'b0;
      rxStatus     <= '0;
    end else begin
      fifoEnQ      <= fifoEn;
      overrunPulse <= !modeFlip && pushAny && rxFull;
      // Trigger level one: raise on a store, drop when a read empties it
      if (str.flush) rxIrq <= 1'b0;
      else if (str.push) rxIrq <= 1'b1;
      else if (str.pop && count == CNT_W'(1)) rxIrq <= 1'b0;
      if (popReq && !modeFlip) rxStatus <= headEntry[DATA_W +: ERR_W];
      else if (statusClr) rxStatus <= '0;
    end
  end
endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo
  import uart_rx_fifo_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DATA_W = 8,
  parameter int ERR_W = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    fifoEn,
  input  logic                    pushValid,
  input  logic [DATA_W+ERR_W-1:0] pushEntry,
  input  logic                    pushBreak,
  input  logic                    popReq,
  output logic [DATA_W+ERR_W-1:0] popEntry,
  input  logic                    statusClr,
  output logic [ERR_W-1:0]        rxStatus,
  output logic                    rxEmpty,
  output logic                    rxFull,
  output logic [7:0]              rxFlags,
  output logic                    rxIrq,
  output logic                    overrunPulse
);
  localparam int ENT_W = DATA_W + ERR_W;
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = PTR_W + 1;
  localparam int BRK_BIT = DATA_W + 2;

  rxqStrobe_t       str;
  logic [CNT_W-1:0] count;

  uart_rx_fifo_ctl #(.DEPTH(DEPTH), .DATA_W(DATA_W), .ERR_W(ERR_W), .CNT_W(CNT_W)) i_ctl (
    .clk(clk), .rstN(rstN), .fifoEn(fifoEn), .pushValid(pushValid),
    .pushBreak(pushBreak), .popReq(popReq), .statusClr(statusClr),
    .count(count), .headEntry(popEntry), .str(str), .rxEmpty(rxEmpty),
    .rxFull(rxFull), .rxIrq(rxIrq), .overrunPulse(overrunPulse),
    .rxStatus(rxStatus)
  );

  uart_rx_fifo_dp #(.DEPTH(DEPTH), .ENT_W(ENT_W), .BRK_BIT(BRK_BIT),
                    .PTR_W(PTR_W), .CNT_W(CNT_W)) i_dp (
    .clk(clk), .rstN(rstN), .str(str), .pushEntry(pushEntry),
    .headEntry(popEntry), .count(count)
  );

  assign rxFlags = {1'b0, rxFull, 1'b0, rxEmpty, 4'b0000};
endmodule

// File: rtl/uart_rx_fifo_chk.sv
module uart_rx_fifo_chk #(
  parameter int ERR_W = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             fifoEn,
  input logic             pushValid,
  input logic             pushBreak,
  input logic             popReq,
  input logic             statusClr,
  input logic             rxEmpty,
  input logic             rxFull,
  input logic             rxIrq,
  input logic             overrunPulse,
  input logic [ERR_W-1:0] rxStatus
);
  p_flags_excl_r6: assert property (@(posedge clk) disable iff (!rstN)
    !(rxEmpty && rxFull));

  p_irq_nonempty_r7: assert property (@(posedge clk) disable iff (!rstN)
    rxIrq == !rxEmpty);

  p_overrun_after_full_r10: assert property (@(posedge clk) disable iff (!rstN)
    overrunPulse |-> $past(rxFull));

  p_status_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
    (statusClr && !popReq) |=> rxStatus == '0);

  p_empty_pop_keeps_r9: assert property (@(posedge clk) disable iff (!rstN)
    (popReq && rxEmpty && !pushValid && !pushBreak) |=> rxEmpty);

  p_single_slot_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!fifoEn && $stable(fifoEn) && !rxEmpty) |-> rxFull);

  p_flip_flush_r4: assert property (@(posedge clk) disable iff (!rstN)
    (fifoEn != $past(fifoEn)) |=> rxEmpty);
endmodule

bind uart_rx_fifo uart_rx_fifo_chk #(.ERR_W(ERR_W)) i_chk (
  .clk(clk), .rstN(rstN), .fifoEn(fifoEn), .pushValid(pushValid),
  .pushBreak(pushBreak), .popReq(popReq), .statusClr(statusClr),
  .rxEmpty(rxEmpty), .rxFull(rxFull), .rxIrq(rxIrq),
  .overrunPulse(overrunPulse), .rxStatus(rxStatus)
);

// File: tb/test_uart_rx_fifo.sv
module test_uart_rx_fifo;
  localparam int DEPTH = 4;
  localparam int ENT_W = 12;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic fifoEn = 1'b0, pushValid = 1'b0, pushBreak = 1'b0, popReq = 1'b0, statusClr = 1'b0;
  logic [ENT_W-1:0] pushEntry = '0;
  logic [ENT_W-1:0] popEntry;
  logic [3:0] rxStatus;
  logic rxEmpty, rxFull, rxIrq, overrunPulse;
  logic [7:0] rxFlags;

  int nChecks = 0, nFails = 0;
  logic [ENT_W-1:0] expQ[$];
  int modelCnt = 0;
  int modelDepth = 1;
  event popEv;
  string popTag = "R2";

  always #5 clk = ~clk;

  uart_rx_fifo #(.DEPTH(DEPTH)) i_uart_rx_fifo (
    .clk(clk), .rstN(rstN), .fifoEn(fifoEn), .pushValid(pushValid),
    .pushEntry(pushEntry), .pushBreak(pushBreak), .popReq(popReq),
    .popEntry(popEntry), .statusClr(statusClr), .rxStatus(rxStatus),
    .rxEmpty(rxEmpty), .rxFull(rxFull), .rxFlags(rxFlags), .rxIrq(rxIrq),
    .overrunPulse(overrunPulse)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Driver: one push per call, records what the model says is kept
  task automatic doPush(logic [ENT_W-1:0] e, bit brk);
    @(negedge clk);
    pushValid = !brk; pushBreak = brk; pushEntry = e;
    if (modelCnt < modelDepth) begin
      expQ.push_back(brk ? 12'h400 : e);
      modelCnt++;
    end
    @(negedge clk);
    pushValid = 1'b0; pushBreak = 1'b0;
  endtask

  task automatic doPop(string tag);
    @(negedge clk);
    popReq = 1'b1; popTag = tag;
    #2 -> popEv;
    @(negedge clk);
    popReq = 1'b0;
    if (modelCnt > 0) modelCnt--;
  endtask

  // Monitor: compares every non-empty read against the scoreboard
  always @(popEv) begin
    if (expQ.size() > 0) check(popTag, popEntry, expQ.pop_front());
  end

  task automatic setMode(bit m);
    @(negedge clk);
    fifoEn = m;
    expQ.delete();
    modelCnt = 0;
    modelDepth = m ? DEPTH : 1;
    @(negedge clk);
  endtask

  initial begin
    #100_000;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nChecks + 1 - nFails, nChecks + 1);
    $finish;
  end

  initial begin
    logic [ENT_W-1:0] first;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 empty", rxEmpty, 1); check("R1 full", rxFull, 0);
    check("R1 irq", rxIrq, 0); check("R1 status", rxStatus, 0);
    check("R1 overrun", overrunPulse, 0);
    check("R6 flags empty", rxFlags, 8'h10);

    // R2 buffered fill
    setMode(1'b1);
    first = 12'h3A5;
    doPush(first, 0); check("R7 irq after push", rxIrq, 1);
    check("R6 not empty", rxEmpty, 0);
    doPush(12'h011, 0); doPush(12'h1FF, 0); doPush(12'h000, 0);
    check("R6 full at depth", rxFull, 1);
    check("R6 flags full", rxFlags, 8'h40);
    // R10 overrun
    doPush(12'h0EE, 0);
    check("R10 overrun pulse", overrunPulse, 1);
    @(negedge clk);
    check("R10 pulse one cycle", overrunPulse, 0);
    doPop("R2 order");
    check("R8 status capture", rxStatus, 4'h3);
    check("R6 full clears on read", rxFull, 0);
    doPop("R2 order"); doPop("R2 order");
    doPop("R10 dropped not stored");
    check("R6 empty again", rxEmpty, 1);
    check("R7 irq cleared", rxIrq, 0);

    // R9 read of empty buffer: head slot has wrapped back to slot 0
    @(negedge clk); popReq = 1'b1; #2;
    check("R9 head slot shown", popEntry, first);
    @(negedge clk); popReq = 1'b0;
    check("R9 stays empty", rxEmpty, 1);
    check("R9 irq stays low", rxIrq, 0);
    check("R8 status from head slot", rxStatus, 4'h3);

    // R8 clear
    @(negedge clk); statusClr = 1'b1; @(negedge clk); statusClr = 1'b0;
    check("R8 cleared", rxStatus, 0);

    // R5 break marker
    doPush(12'h0FF, 1);
    doPop("R5 break entry");
    check("R5 break status bit", rxStatus, 4'h4);

    // R2 wrap-around
    doPush(12'h101, 0); doPush(12'h202, 0); doPush(12'h303, 0);
    doPop("R2 wrap"); doPop("R2 wrap");
    doPush(12'h404, 0); doPush(12'h505, 0); doPush(12'h606, 0);
    check("R6 full after wrap", rxFull, 1);
    repeat (4) doPop("R2 wrap");
    check("R6 empty after wrap", rxEmpty, 1);

    // R4 flush on mode change with data held
    doPush(12'h0AA, 0); doPush(12'h0BB, 0);
    setMode(1'b0);
    check("R4 flushed empty", rxEmpty, 1);
    check("R4 irq dropped", rxIrq, 0);
    check("R4 not full", rxFull, 0);

    // R3 holding mode
    doPush(12'h055, 0);
    check("R3 full after one", rxFull, 1);
    doPush(12'h066, 0);
    check("R3 second push overruns", overrunPulse, 1);
    doPop("R3 holds first");
    check("R3 empty after read", rxEmpty, 1);
    doPush(12'h077, 0);
    doPop("R3 single slot reused");

    // R4 flush on the other edge
    doPush(12'h088, 0);
    setMode(1'b1);
    check("R4 flush on enable", rxEmpty, 1);

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule